// File: doc/BRIEF.md
# Decode-Stage Address Generation Pipeline

A three-stage in-order pipeline (fetch, decode, execute) for a small instruction set. Its purpose is to make one timing relationship visible and testable. Operand addresses and jump targets are formed in decode, from an eight-entry address-register file. Register and mode writes land only at the end of execute. There is no interlock and no forwarding. An instruction that uses an address register right after the instruction that writes it therefore sees the old contents. One intervening instruction is enough for the new contents to be seen.

A mode register selects which memory bank instructions are fetched from: a boot ROM bank or a program RAM bank. A jump latches its target address together with the bank chosen by the mode as decode sees it. A jump placed directly after a mode write therefore lands in the old bank. The following sequential fetch then comes from the new bank. The instruction memory sits outside the block. The block drives a fetch address and a bank bit, and takes back one instruction word per cycle. Indirect loads appear on a data-address output. A debug port reads any address register combinationally.

Top module: `decode_addr_pipe`

## Requirements
- R1: While reset is held, and at the first cycle after it, the fetch address is 0, the fetch bank is 0 (boot ROM), the data enable is 0, every address register reads 0 and the mode register holds 0.
- R2: With no jump in decode, the fetch address advances by one each cycle and stays in the current bank.
- R3: An immediate load (word bits [15:12] = 1, register in bits [11:9], value in bits [7:0]) writes the value into the named register at the clock edge that ends its execute stage.
- R4: An indirect load (bits [15:12] = 2, register in bits [11:9]) raises the data enable for exactly one cycle: the cycle after its decode. The data address in that cycle is the named register's value as decode read it.
- R5: An indirect load that directly follows an immediate load to the same register uses the register's previous value. There is no stall and no bypass.
- R6: With one or more other instructions between the immediate load and the indirect load, the indirect load uses the newly written value.
- R7: A jump (bits [15:12] = 3, target in bits [7:0]) makes the next fetch address equal to the target. The instruction fetched directly after the jump is discarded and changes no register.
- R8: A mode write (bits [15:12] = 4, mode in bits [1:0]) takes effect at the end of execute. A jump that directly follows it fetches its target from the bank of the old mode. The next sequential fetch uses the new mode.
- R9: With one or two instructions between a mode write of 2 and a jump, the jump target is fetched from the program RAM bank (bank bit 1).
- R10: Only mode value 2 selects the program RAM bank. Mode values 0, 1 and 3 keep fetching from the boot ROM bank.
- R11: Opcodes other than 1 to 4 behave as no-operations. They write no register, issue no data access and do not redirect fetch.
- R12: The debug port returns the current contents of the register chosen by the debug select input, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word at the current fetch address and bank |
| fetch_addr_o | output | 8 | Instruction fetch address |
| fetch_bank_o | output | 1 | Fetch bank: 0 boot ROM, 1 program RAM |
| dmem_en_o | output | 1 | Indirect load issued this cycle |
| dmem_addr_o | output | 8 | Data address of the indirect load |
| dbg_sel_i | input | 3 | Debug register select |
| dbg_data_o | output | 8 | Contents of the selected address register |

## Verification
The register hazard is swept over all eight registers. For each one, the gap between the immediate load and the indirect load is zero, one or two instructions, and the gaps are filled with undefined opcodes that name the same register. A zero gap must yield the old value, any non-zero gap the new value, and the filler must leave every register untouched. The bank hazard is swept over all four mode values and gaps of zero to two instructions before a jump. Different words are placed at the target and at the target plus one in both banks. The register that ends up loaded therefore shows which bank each fetch came from, and a load placed in the squashed slot shows whether the discard works.

// File: rtl/dap_pkg.sv
package dap_pkg;

    localparam int IW       = 16;
    localparam int AW       = 8;
    localparam int NREG     = 8;
    localparam int RSEL_W   = $clog2(NREG);
    localparam int MODE_W   = 2;
    localparam int OP_W     = 4;
    localparam int OP_LSB   = 12;
    localparam int RN_LSB   = 9;

    localparam logic [MODE_W-1:0] MODE_BOOT = MODE_W'(0);
    localparam logic [MODE_W-1:0] MODE_RUN  = MODE_W'(2);
    localparam logic [IW-1:0]     NOP_WORD  = '0;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 4'h0,
        OP_LDI     = 4'h1,
        OP_LDIND   = 4'h2,
        OP_JMP     = 4'h3,
        OP_SETMODE = 4'h4
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [RSEL_W-1:0] rn;
        logic [AW-1:0]     imm;
    } fields_s;

    typedef struct packed {
        op_e               op;
        logic [RSEL_W-1:0] rn;
        logic [AW-1:0]     imm;
        logic [AW-1:0]     ea;
    } dec_s;

    function automatic fields_s crack(input logic [IW-1:0] w);
        fields_s f;
        case (w[OP_LSB +: OP_W])
            4'h1:    f.op = OP_LDI;
            4'h2:    f.op = OP_LDIND;
            4'h3:    f.op = OP_JMP;
            4'h4:    f.op = OP_SETMODE;
            default: f.op = OP_NOP;
        endcase
        f.rn  = w[RN_LSB +: RSEL_W];
        f.imm = w[AW-1:0];
        return f;
    endfunction

    function automatic logic bank_of(input logic [MODE_W-1:0] m);
        return m == MODE_RUN;
    endfunction

endpackage

// File: rtl/dap_fetch.sv
module dap_fetch
    import dap_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] instr_word,
    input  logic          jump_taken,
    input  logic [AW-1:0] jump_target,
    input  logic          mode_bank,
    output logic [AW-1:0] fetch_addr,
    output logic          fetch_bank,
    output logic [IW-1:0] id_word
);

    logic [AW-1:0] pc_q;
    logic          bank_q;
    logic [IW-1:0] id_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            bank_q <= 1'b0;
            id_q   <= NOP_WORD;
        end else if (jump_taken) begin
            pc_q   <= jump_target;
            bank_q <= mode_bank;
            id_q   <= NOP_WORD;
        end else begin
            pc_q   <= pc_q + AW'(1);
            bank_q <= mode_bank;
            id_q   <= instr_word;
        end
    end

    assign fetch_addr = pc_q;
    assign fetch_bank = bank_q;
    assign id_word    = id_q;

endmodule

// File: rtl/dap_decode.sv
module dap_decode
    import dap_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [IW-1:0]            id_word,
    input  logic [NREG-1:0][AW-1:0]  rf_q,
    output logic                     jump_taken,
    output logic [AW-1:0]            jump_target,
    output dec_s                     ex_q
);

    fields_s f;
    dec_s    d;

    always_comb begin
        f           = crack(id_word);
        d.op        = f.op;
        d.rn        = f.rn;
        d.imm       = f.imm;
        d.ea        = rf_q[f.rn];
        jump_taken  = (f.op == OP_JMP);
        jump_target = f.imm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_q <= '{op: OP_NOP, rn: '0, imm: '0, ea: '0};
        end else begin
            ex_q <= d;
        end
    end

endmodule

// File: rtl/dap_regfile.sv
module dap_regfile
    import dap_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  dec_s                     ex_q,
    input  logic [RSEL_W-1:0]        dbg_sel,
    output logic [NREG-1:0][AW-1:0]  rf_q,
    output logic [MODE_W-1:0]        mode_q,
    output logic [AW-1:0]            dbg_data
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                rf_q[i] <= '0;
            end else if (ex_q.op == OP_LDI && ex_q.rn == RSEL_W'(i)) begin
                rf_q[i] <= ex_q.imm;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_BOOT;
        end else if (ex_q.op == OP_SETMODE) begin
            mode_q <= ex_q.imm[MODE_W-1:0];
        end
    end

    assign dbg_data = rf_q[dbg_sel];

endmodule

// File: rtl/decode_addr_pipe.sv
module decode_addr_pipe
    import dap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IW-1:0]     instr_i,
    output logic [AW-1:0]     fetch_addr_o,
    output logic              fetch_bank_o,
    output logic              dmem_en_o,
    output logic [AW-1:0]     dmem_addr_o,
    input  logic [RSEL_W-1:0] dbg_sel_i,
    output logic [AW-1:0]     dbg_data_o
);

    logic                    jump_taken;
    logic [AW-1:0]           jump_target;
    logic [IW-1:0]           id_word;
    dec_s                    ex_q;
    logic [NREG-1:0][AW-1:0] rf_q;
    logic [MODE_W-1:0]       mode_q;

    dap_fetch u_fetch (
        .clk         (clk),
        .rst         (rst),
        .instr_word  (instr_i),
        .jump_taken  (jump_taken),
        .jump_target (jump_target),
        .mode_bank   (bank_of(mode_q)),
        .fetch_addr  (fetch_addr_o),
        .fetch_bank  (fetch_bank_o),
        .id_word     (id_word)
    );

    dap_decode u_decode (
        .clk         (clk),
        .rst         (rst),
        .id_word     (id_word),
        .rf_q        (rf_q),
        .jump_taken  (jump_taken),
        .jump_target (jump_target),
        .ex_q        (ex_q)
    );

    dap_regfile u_regfile (
        .clk      (clk),
        .rst      (rst),
        .ex_q     (ex_q),
        .dbg_sel  (dbg_sel_i),
        .rf_q     (rf_q),
        .mode_q   (mode_q),
        .dbg_data (dbg_data_o)
    );

    assign dmem_en_o   = (ex_q.op == OP_LDIND);
    assign dmem_addr_o = ex_q.ea;

endmodule

// File: rtl/decode_addr_pipe_chk.sv
module decode_addr_pipe_chk
    import dap_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic [AW-1:0]           fetch_addr,
    input logic                    fetch_bank,
    input logic                    dmem_en,
    input logic                    jump_taken,
    input logic [AW-1:0]           jump_target,
    input logic [MODE_W-1:0]       mode_q,
    input logic [IW-1:0]           id_word,
    input dec_s                    ex_q,
    input logic [NREG-1:0][AW-1:0] rf_q
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fetch_addr == '0 && !fetch_bank && !dmem_en && mode_q == MODE_BOOT));

    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(jump_taken)) |-> fetch_addr == $past(fetch_addr) + AW'(1));

    assert_ldi_write_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ex_q.op) == OP_LDI) |-> rf_q[$past(ex_q.rn)] == $past(ex_q.imm));

    assert_ldind_issue_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(id_word[OP_LSB +: OP_W]) == 4'h2) |-> dmem_en);

    assert_jump_squash_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(jump_taken)) |-> (fetch_addr == $past(jump_target) && id_word == NOP_WORD));

    assert_jump_bank_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(jump_taken)) |-> fetch_bank == ($past(mode_q) == MODE_RUN));

endmodule

bind decode_addr_pipe decode_addr_pipe_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_addr  (fetch_addr_o),
    .fetch_bank  (fetch_bank_o),
    .dmem_en     (dmem_en_o),
    .jump_taken  (jump_taken),
    .jump_target (jump_target),
    .mode_q      (mode_q),
    .id_word     (id_word),
    .ex_q        (ex_q),
    .rf_q        (rf_q)
);

// File: tb/decode_addr_pipe_bench.sv
module decode_addr_pipe_bench;
    import dap_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [IW-1:0]     instr;
    logic [AW-1:0]     fetch_addr;
    logic              fetch_bank;
    logic              dmem_en;
    logic [AW-1:0]     dmem_addr;
    logic [RSEL_W-1:0] dbg_sel = '0;
    logic [AW-1:0]     dbg_data;

    logic [IW-1:0] rom [256];
    logic [IW-1:0] ram [256];

    logic [AW-1:0] tr_addr [32];
    logic          tr_bank [32];
    logic          tr_en   [32];
    logic [AW-1:0] tr_dma  [32];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    assign instr = fetch_bank ? ram[fetch_addr] : rom[fetch_addr];

    decode_addr_pipe u_decode_addr_pipe (
        .clk          (clk),
        .rst          (rst),
        .instr_i      (instr),
        .fetch_addr_o (fetch_addr),
        .fetch_bank_o (fetch_bank),
        .dmem_en_o    (dmem_en),
        .dmem_addr_o  (dmem_addr),
        .dbg_sel_i    (dbg_sel),
        .dbg_data_o   (dbg_data)
    );

    function automatic logic [IW-1:0] enc(input logic [3:0] op, input logic [2:0] rn,
                                          input logic [7:0] imm);
        return {op, rn, 1'b0, imm};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int a = 0; a < 256; a++) begin
            rom[a] = NOP_WORD;
            ram[a] = NOP_WORD;
        end
    endtask

    task automatic run(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < cycles; c++) begin
            tr_addr[c] = fetch_addr;
            tr_bank[c] = fetch_bank;
            tr_en[c]   = dmem_en;
            tr_dma[c]  = dmem_addr;
            @(negedge clk);
        end
    endtask

    task automatic read_reg(input int r, output logic [AW-1:0] v);
        dbg_sel = RSEL_W'(r);
        #1;
        v = dbg_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] v;
        // Register hazard sweep: R2 R3 R4 R5 R6 R11 R12
        for (int n = 0; n < 8; n++) begin
            for (int d = 0; d < 3; d++) begin
                logic [7:0] oldv, newv;
                int p, ens;
                oldv = 8'(n * 16 + 3);
                newv = 8'(8'hF0 - n * 5 + d);
                p = 4 + d;
                clear_mem();
                rom[0] = enc(4'h1, 3'(n), oldv);
                rom[3] = enc(4'h1, 3'(n), newv);
                for (int g = 0; g < d; g++) rom[4 + g] = enc(4'(4'h8 + g), 3'(n), 8'hEE);
                rom[p] = enc(4'h2, 3'(n), 8'h00);
                run(14);
                check(tr_en[p + 2] == 1'b1, "R4", int'(tr_en[p + 2]), 1);
                if (d == 0)
                    check(tr_dma[p + 2] == oldv, "R5", int'(tr_dma[p + 2]), int'(oldv));
                else
                    check(tr_dma[p + 2] == newv, "R6", int'(tr_dma[p + 2]), int'(newv));
                ens = 0;
                for (int c = 0; c < 14; c++) ens += int'(tr_en[c]);
                check(ens == 1, "R4", ens, 1);
                if (n == 0) begin
                    for (int c = 0; c < 14; c++)
                        check(tr_addr[c] == AW'(c) && !tr_bank[c], "R2", int'(tr_addr[c]), c);
                end
                for (int r = 0; r < 8; r++) begin
                    read_reg(r, v);
                    if (r == n) check(v == newv, "R3", int'(v), int'(newv));
                    else check(v == '0, "R11_R12", int'(v), 0);
                end
            end
        end

        // Bank hazard sweep: R7 R8 R9 R10
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 3; k++) begin
                int j;
                logic [7:0] t;
                logic bt, bt1;
                logic [7:0] e2, e3;
                j = 1 + k;
                t = 8'(8'h40 + m * 4 + k);
                bt  = (m == 2) && (k >= 1);
                bt1 = (m == 2);
                e2 = bt  ? 8'hB0 : 8'hA0;
                e3 = bt1 ? 8'h32 : 8'h31;
                clear_mem();
                rom[0] = enc(4'h4, 3'd0, 8'(m));
                rom[j] = enc(4'h3, 3'd0, t);
                rom[j + 1] = enc(4'h1, 3'd1, 8'h55);
                ram[j + 1] = enc(4'h1, 3'd1, 8'h55);
                rom[t] = enc(4'h1, 3'd2, 8'hA0);
                ram[t] = enc(4'h1, 3'd2, 8'hB0);
                rom[t + 1] = enc(4'h1, 3'd3, 8'h31);
                ram[t + 1] = enc(4'h1, 3'd3, 8'h32);
                run(16);
                check(tr_addr[j + 2] == t, "R7", int'(tr_addr[j + 2]), int'(t));
                check(tr_addr[j + 3] == t + 8'd1, "R7", int'(tr_addr[j + 3]), int'(t) + 1);
                if (k == 0)
                    check(tr_bank[j + 2] == bt, "R8", int'(tr_bank[j + 2]), int'(bt));
                else if (m == 2)
                    check(tr_bank[j + 2] == bt, "R9", int'(tr_bank[j + 2]), int'(bt));
                else
                    check(tr_bank[j + 2] == bt, "R10", int'(tr_bank[j + 2]), int'(bt));
                check(tr_bank[j + 3] == bt1, "R8_R10", int'(tr_bank[j + 3]), int'(bt1));
                read_reg(1, v);
                check(v == '0, "R7", int'(v), 0);
                read_reg(2, v);
                check(v == e2, "R8_R9", int'(v), int'(e2));
                read_reg(3, v);
                check(v == e3, "R8_R10", int'(v), int'(e3));
            end
        end

        // Reset state: R1
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(fetch_addr == '0, "R1", int'(fetch_addr), 0);
        check(fetch_bank == 1'b0, "R1", int'(fetch_bank), 0);
        check(dmem_en == 1'b0, "R1", int'(dmem_en), 0);
        for (int r = 0; r < 8; r++) begin
            read_reg(r, v);
            check(v == '0, "R1", int'(v), 0);
        end
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule